// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block runs one acquisition cycle of an eight-channel converter that freezes all of its inputs at the same moment. A channel enable mask says which inputs take part. A cycle can be started in three ways: a software read of the start location, or the falling edge of one of two hardware triggers. The block raises a hold line so that every input is sampled together. It then asks an external converter for one result per enabled channel, lowest channel first, and puts the 14-bit results into a small FIFO.

An active-low end-of-conversion flag goes low once the last enabled channel has been stored. It stays low until the next cycle begins. Software reads the results through eight mirrored data addresses that all pop the same FIFO. Any two neighbouring addresses therefore give two consecutive results when a wide access is split into two halfword reads.

A trigger select bit picks the hardware source. With the bit at 0 the external trigger pin is used, and with the bit at 1 the timer output is used. Each trigger pin is synchronised with two flops before its falling edge is detected.

Top module: `adc_scan_seq`

## Requirements
- R1: Bit n of the channel mask (written with `mask_we`) enables channel n. During a cycle the converter is asked only for enabled channels, and it is asked once for each of them.
- R2: A read (`rd_en`) at word index 16 starts a cycle. `conv_hold` is high in the cycle after that read is sampled.
- R3: With `trig_sel` = 0, a falling edge on `ext_trig_n` starts a cycle and `tmr_out` has no effect. With `trig_sel` = 1, a falling edge on `tmr_out` starts a cycle and `ext_trig_n` has no effect.
- R4: All enabled inputs are held together. `conv_hold` is high for one cycle before the first `conv_req`, and it stays high until the last result has been accepted.
- R5: `eoc_n` is 1 after reset and while a cycle runs. It falls one cycle after the last result is stored. It stays 0, through data reads as well, until the next start.
- R6: Starting a cycle empties the FIFO, so results that were never read from the previous cycle are lost.
- R7: Results come out in ascending channel order, lowest-numbered enabled channel first.
- R8: Each result passes through unchanged as a 14-bit two's complement value (0x2000 most negative, 0x1FFF most positive, 0x0000 zero). Bits 15:14 of `rd_data` are always 0.
- R9: A read at any word index from 0 to 7 pops the same FIFO. `rd_data` holds the popped value from the cycle after the read.
- R10: A start request that arrives while a cycle is running is ignored. The running cycle completes with all of its results.
- R11: With an all-zero mask, a start completes with no converter request. `eoc_n` is 0 by the third edge after the start, and the FIFO is empty.
- R12: A data read from an empty FIFO returns 0. It does not disturb the FIFO pointers, so later cycles read back correctly.
- R13: A hardware trigger edge is seen through a two-flop synchronizer. If the pin falls before edge 1, `conv_hold` rises at edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_we | input | 1 | Channel mask write strobe |
| mask_wdata | input | 8 | Channel mask, bit n enables channel n |
| trig_sel | input | 1 | Hardware trigger select: 0 external pin, 1 timer |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 5 | Halfword index: 0..7 data mirrors, 16 start |
| rd_data | output | 16 | Popped result, zero-extended, valid the cycle after a read |
| tmr_out | input | 1 | Timer output trigger (falling edge) |
| ext_trig_n | input | 1 | External trigger pin (falling edge) |
| conv_hold | output | 1 | Sample-and-hold command to the converter |
| conv_req | output | 1 | Conversion request for `conv_ch` |
| conv_ch | output | 3 | Channel being converted |
| conv_ack | input | 1 | Converter result valid |
| conv_result | input | 14 | Converter result |
| eoc_n | output | 1 | End of conversion, active low |

## Verification
A software start shows up on `conv_hold` one edge after the read is sampled. A hardware trigger takes three edges from the pin to the hold line. The bench checks at the falling edge after the expected rising edge, and it also checks that the edge before is still low. A data read returns its value after one edge, so each read task samples at the next falling edge. Completion is awaited by polling `eoc_n` on falling edges. Expected results are queued in channel order when the bench asks for a cycle and are compared as each read returns.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int unsigned NCH       = 8;
  localparam int unsigned RES_W     = 14;
  localparam int unsigned BUS_W     = 16;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned START_IDX = 16;
  localparam int unsigned CH_W      = $clog2(NCH);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_SCAN   = 2'd2
  } scan_state_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign fall = prev_q & ~sync_q;
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wr_q, wr_d, rd_q, rd_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          full, do_push, do_pop;

  assign empty   = (wr_q == rd_q);
  assign full    = (wr_q[AW-1:0] == rd_q[AW-1:0]) && (wr_q[AW] != rd_q[AW]);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wr_d    = wr_q;
    rd_d    = rd_q;
    rdata_d = rdata_q;
    if (flush) begin
      wr_d = '0;
      rd_d = '0;
    end else begin
      if (do_push) wr_d = wr_q + 1'b1;
      if (do_pop)  rd_d = rd_q + 1'b1;
    end
    if (pop) rdata_d = do_pop ? mem[rd_q[AW-1:0]] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      rdata_q <= '0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q[AW-1:0]] <= wdata;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic [NCH-1:0]  mask_wdata,
  input  logic            start_req,
  input  logic            conv_ack,
  output logic            start_go,
  output logic            conv_hold,
  output logic            conv_req,
  output logic [CH_W-1:0] conv_ch,
  output logic            push,
  output logic            eoc_n
);
  scan_state_e    state_q, state_d;
  logic [NCH-1:0] mask_q, pend_q, pend_d;
  logic           eoc_q, eoc_d;
  logic [CH_W-1:0] low_ch;

  // lowest pending channel: descending scan leaves the smallest index
  always_comb begin
    low_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend_q[i]) low_ch = CH_W'(i);
    end
  end

  assign start_go  = (state_q == ST_IDLE) && start_req;
  assign conv_hold = (state_q != ST_IDLE);
  assign conv_req  = (state_q == ST_SCAN) && (pend_q != '0);
  assign conv_ch   = low_ch;
  assign push      = conv_req && conv_ack;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    eoc_d   = eoc_q;
    unique case (state_q)
      ST_IDLE: if (start_go) begin
        state_d = ST_SAMPLE;
        pend_d  = mask_q;
        eoc_d   = 1'b1;
      end
      ST_SAMPLE: state_d = ST_SCAN;
      ST_SCAN: begin
        if (pend_q == '0) begin
          state_d = ST_IDLE;
          eoc_d   = 1'b0;
        end else if (conv_ack) begin
          pend_d[low_ch] = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      eoc_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      eoc_q   <= eoc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign eoc_n = eoc_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [NCH-1:0]    mask_wdata,
  input  logic              trig_sel,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  input  logic              tmr_out,
  input  logic              ext_trig_n,
  output logic              conv_hold,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_ack,
  input  logic [RES_W-1:0]  conv_result,
  output logic              eoc_n
);
  localparam int unsigned NTRIG = 2;

  logic [NTRIG-1:0] trig_pins, trig_fall;
  logic             data_hit, start_hit, hw_start, start_go, push, fifo_empty;
  logic [RES_W-1:0] fifo_q;

  assign trig_pins = {tmr_out, ext_trig_n};

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    adc_trig_sync u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (trig_pins[g]),
      .fall (trig_fall[g])
    );
  end

  assign hw_start  = trig_sel ? trig_fall[1] : trig_fall[0];
  assign data_hit  = rd_en && (rd_addr < ADDR_W'(NCH));
  assign start_hit = rd_en && (rd_addr == ADDR_W'(START_IDX));

  adc_scan_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (mask_we),
    .mask_wdata(mask_wdata),
    .start_req (start_hit || hw_start),
    .conv_ack  (conv_ack),
    .start_go  (start_go),
    .conv_hold (conv_hold),
    .conv_req  (conv_req),
    .conv_ch   (conv_ch),
    .push      (push),
    .eoc_n     (eoc_n)
  );

  adc_result_fifo #(.DEPTH(NCH), .DW(RES_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(start_go),
    .push (push),
    .wdata(conv_result),
    .pop  (data_hit),
    .rdata(fifo_q),
    .empty(fifo_empty)
  );

  assign rd_data = {{(BUS_W - RES_W){1'b0}}, fifo_q};
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
  import adc_scan_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BUS_W-1:0] rd_data,
  input logic             conv_hold,
  input logic             conv_req,
  input logic [CH_W-1:0]  conv_ch,
  input logic             conv_ack,
  input logic             eoc_n,
  input logic             start_go,
  input logic             fifo_empty
);
  // R4
  req_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (conv_hold && eoc_n));

  // R7
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_ack) |=> (conv_req && $stable(conv_ch)));

  // R5
  eoc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_n) |-> $past(start_go));

  // R5
  eoc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n) |-> $past(conv_hold));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:RES_W] == '0);

  // R12
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr < ADDR_W'(NCH) && fifo_empty && !start_go) |=> (rd_data == '0));
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .conv_hold (conv_hold),
  .conv_req  (conv_req),
  .conv_ch   (conv_ch),
  .conv_ack  (conv_ack),
  .eoc_n     (eoc_n),
  .start_go  (start_go),
  .fifo_empty(fifo_empty)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mask_we = 1'b0;
  logic [7:0]  mask_wdata = '0;
  logic        trig_sel = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        tmr_out = 1'b0;
  logic        ext_trig_n = 1'b1;
  logic        conv_hold, conv_req, eoc_n;
  logic [2:0]  conv_ch;
  logic        conv_ack;
  logic [13:0] conv_result;

  int checks = 0;
  int errors = 0;
  int bad_req = 0;
  int req_seen = 0;
  int cyc = 0;
  bit finished = 0;
  logic [7:0]  cur_mask = '0;
  logic [13:0] vals [8];
  logic [15:0] exp_q [$];
  logic [1:0]  wait_cnt;

  always #2 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .trig_sel(trig_sel), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tmr_out(tmr_out), .ext_trig_n(ext_trig_n), .conv_hold(conv_hold),
    .conv_req(conv_req), .conv_ch(conv_ch), .conv_ack(conv_ack),
    .conv_result(conv_result), .eoc_n(eoc_n)
  );

  // converter model: answers each request after two waiting cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_ack    <= 1'b0;
      conv_result <= '0;
      wait_cnt    <= '0;
    end else if (conv_ack) begin
      conv_ack <= 1'b0;
    end else if (conv_req) begin
      if (wait_cnt == 2'd2) begin
        conv_ack    <= 1'b1;
        conv_result <= vals[conv_ch];
        wait_cnt    <= '0;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  // R1 request monitor
  always @(negedge clk) begin
    if (rst_n && conv_req) begin
      req_seen++;
      if (!cur_mask[conv_ch]) bad_req++;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_mask(logic [7:0] m);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = m;
    @(negedge clk);
    mask_we = 1'b0;
    cur_mask = m;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // driver: push expected results of a cycle in ascending channel order
  task automatic expect_cycle();
    exp_q.delete();
    for (int i = 0; i < 8; i++)
      if (cur_mask[i]) exp_q.push_back({2'b00, vals[i]});
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400; i++) begin
      if (!eoc_n) break;
      @(negedge clk);
    end
  endtask

  // monitor: read results at rotating mirror addresses and compare
  task automatic drain(string req);
    logic [15:0] d;
    int k = 0;
    while (exp_q.size() > 0) begin
      bus_read(5'(k % 8), d);
      chk(req, d, exp_q.pop_front());
      k += 3;
    end
    bus_read(5'd5, d);
    chk("R12 empty read", d, 16'h0000);
  endtask

  task automatic sw_start();
    logic [15:0] d;
    bus_read(5'd16, d);
  endtask

  initial begin
    logic [15:0] d;
    vals[0] = 14'h2000; vals[1] = 14'h1FFF; vals[2] = 14'h0000; vals[3] = 14'h0123;
    vals[4] = 14'h3FFF; vals[5] = 14'h0A5A; vals[6] = 14'h1000; vals[7] = 14'h2468;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 eoc after reset", 16'(eoc_n), 16'h1);
    chk("R2 hold idle", 16'(conv_hold), 16'h0);
    bus_read(5'd0, d);
    chk("R12 read empty after reset", d, 16'h0);

    // R1 R2 R4 R7 R9 R8
    set_mask(8'hA5);
    expect_cycle();
    sw_start();
    chk("R2 hold after start", 16'(conv_hold), 16'h1);
    chk("R4 no request in sample cycle", 16'(conv_req), 16'h0);
    chk("R5 eoc high while running", 16'(eoc_n), 16'h1);
    wait_done();
    chk("R5 eoc low at end", 16'(eoc_n), 16'h0);
    chk("R4 hold released", 16'(conv_hold), 16'h0);
    drain("R7 R9 ordered result");
    chk("R5 eoc low after reads", 16'(eoc_n), 16'h0);

    // R10 start while running; R8 extremes
    set_mask(8'hFF);
    expect_cycle();
    sw_start();
    while (!conv_req) @(negedge clk);
    sw_start();
    wait_done();
    drain("R10 R8 full cycle");

    // R6 flush unread results
    set_mask(8'h0F);
    sw_start();
    wait_done();
    set_mask(8'h30);
    expect_cycle();
    sw_start();
    chk("R6 eoc high on restart", 16'(eoc_n), 16'h1);
    wait_done();
    drain("R6 only new results");

    // R11 zero mask
    set_mask(8'h00);
    req_seen = 0;
    expect_cycle();
    sw_start();
    repeat (2) @(negedge clk);
    chk("R11 zero mask done", 16'(eoc_n), 16'h0);
    chk("R11 no converter request", 16'(req_seen), 16'h0);
    drain("R11 empty");

    // R13 R3 external trigger path
    set_mask(8'h42);
    trig_sel = 1'b0;
    expect_cycle();
    ext_trig_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R13 hold low after two edges", 16'(conv_hold), 16'h0);
    @(negedge clk);
    chk("R13 hold high after three edges", 16'(conv_hold), 16'h1);
    ext_trig_n = 1'b1;
    wait_done();
    drain("R3 external trigger results");

    // R3 timer ignored while external selected
    tmr_out = 1'b1; repeat (4) @(negedge clk);
    tmr_out = 1'b0; repeat (6) @(negedge clk);
    chk("R3 timer ignored sel0", 16'(conv_hold), 16'h0);

    // R3 timer selected: external ignored, timer starts
    trig_sel = 1'b1;
    ext_trig_n = 1'b0; repeat (4) @(negedge clk);
    ext_trig_n = 1'b1; repeat (6) @(negedge clk);
    chk("R3 external ignored sel1", 16'(conv_hold), 16'h0);
    set_mask(8'h81);
    expect_cycle();
    tmr_out = 1'b1; repeat (4) @(negedge clk);
    tmr_out = 1'b0; repeat (3) @(negedge clk);
    chk("R3 timer starts sel1", 16'(conv_hold), 16'h1);
    wait_done();
    drain("R3 timer trigger results");

    chk("R1 requests only for enabled channels", 16'(bad_req), 16'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule